// File: doc/BRIEF.md
# External Memory Bus Controller

This block turns single requests from an on-chip master into timed cycles on an external asynchronous bus, the kind used by SRAM, NOR flash and simple memory-mapped peripherals. A request carries an address, write data, a four-bit lane mask and a direction, and it is handed over with a valid/ready handshake. The controller compares the address with a set of programmable windows. Each window has a base, a don't-care mask, an enable, a wait-state count and two option bits. The controller then drives the chosen active-low chip select together with the byte enables, output enable, read/write line and transfer-start strobe.

A global mode input selects one of two bus layouts. In the separate layout the address has its own output and the data bus carries only data. In the multiplexed layout the address goes out on the shared address/data bus during the start phase, and an address latch enable marks that phase. Each transfer ends with a one-cycle done pulse. On a read, the pulse comes with the captured data. If no window claims the address, the pulse comes with an error flag.

Top module: `xbus_ctrl`

## Requirements
- R1: Window i matches when `win_en[i]` is 1 and every address bit whose `win_mask[i]` bit is 0 equals the same bit of `win_base[i]`. Mask bits set to 1 are don't-care. Only the matched window's `bus_cs_n` bit goes low, and only during the access phase.
- R2: When several windows match, the lowest-numbered one is used, so at most one chip select is low at any time.
- R3: During the access phase of a write, `bus_be_n` equals the inverse of `req_lanes` (bit k low means lane k, data bits 8k+7..8k, is active). At all other times it is 4'hF.
- R4: When `win_wr_only` of the selected window is 1, `bus_be_n` stays 4'hF during reads. When it is 0, reads drive the byte enables the same way writes do.
- R5: `bus_oe_n` is low only during the access phase of a read to a matched window.
- R6: `bus_rw` is 1 for reads and when idle, and 0 during the start and access phases of a write.
- R7: After a request is accepted, the next cycle is the start phase. In that cycle `bus_ts_n` is low, no chip select is low and `bus_addr` holds the request address. The access phase begins in the following cycle.
- R8: When `win_exts` of the selected window is 1, `bus_ts_n` also stays low in the first access cycle, which is the first cycle with chip select low. It goes high at the clock edge after that cycle.
- R9: When `cfg_muxed` is 1, `bus_ale` is the inverse of `bus_ts_n`, and `bus_ad_out` carries the address with `bus_ad_oe` high while `bus_ts_n` is low in the start phase. When `cfg_muxed` is 0, `bus_ale` stays 0.
- R10: The access phase lasts `win_ws`+1 cycles, where `win_ws` is 0 to 15. A read captures `bus_ad_in` at the clock edge that ends the last access cycle. During write access cycles `bus_ad_out` carries the write data with `bus_ad_oe` high.
- R11: `rsp_done` is high for exactly one cycle, the cycle right after the last access cycle. In that cycle all chip selects, `bus_ts_n` and `bus_oe_n` are already high, `rsp_err` is 0, and on a read `rsp_rdata` holds the captured data.
- R12: A request that matches no window drives no bus strobe. In the cycle after acceptance it produces `rsp_done` with `rsp_err` equal to 1.
- R13: `req_ready` is 1 only while no transfer is in its start or access phase. A request is taken at a rising edge where `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_muxed | input | 1 | 1 selects the multiplexed address/data layout |
| win_en | input | NWIN | Per-window enable |
| win_base | input | NWIN x 32 | Per-window base address |
| win_mask | input | NWIN x 32 | Per-window don't-care mask (1 = ignore bit) |
| win_ws | input | NWIN x 4 | Per-window wait-state count |
| win_exts | input | NWIN | Per-window strobe-stretch option |
| win_wr_only | input | NWIN | Per-window byte enables on writes only |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Request write data |
| req_lanes | input | 4 | Active byte lanes, bit k = lane k |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | No-match error, valid with rsp_done |
| rsp_rdata | output | 32 | Read data, valid with rsp_done on a read |
| bus_cs_n | output | NWIN | Active-low chip selects |
| bus_be_n | output | 4 | Active-low byte enables |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_ts_n | output | 1 | Active-low transfer-start strobe |
| bus_ale | output | 1 | Address latch enable (multiplexed layout) |
| bus_addr | output | 32 | Address during a transfer, 0 when idle |
| bus_ad_out | output | 32 | Driven value of the address/data bus |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_out |
| bus_ad_in | input | 32 | Sampled value of the address/data bus |

## Verification
Addresses are chosen to land in each window in turn. One of them falls in two overlapping windows, which separates priority from plain matching. Two others fall in a disabled window or outside every window, which exercises the error path. The windows combine wait counts of 0, 1, 2, 3 and 15 with and without the strobe stretch, so an off-by-one in the access length or in the stretch shows up as a strobe one cycle too long or too short. Reads and writes go to windows with the write-only byte-enable option both set and clear. The whole sequence then runs again with the multiplexed layout, so address-phase driving of the shared bus and the latch enable are checked against the separate layout.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int AW        = 32;
    localparam int DW        = 32;
    localparam int BW        = DW / 8;
    localparam int WS_W      = 4;
    localparam int MAX_WIN   = 8;
    localparam int WIN_IDX_W = $clog2(MAX_WIN);

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_START  = 2'd1,
        PH_ACCESS = 2'd2
    } phase_t;

    typedef struct packed {
        logic [AW-1:0]        addr;
        logic [DW-1:0]        wdata;
        logic [BW-1:0]        lanes;
        logic                 write;
        logic [WIN_IDX_W-1:0] win;
        logic [WS_W-1:0]      ws;
        logic                 exts;
        logic                 wr_only;
    } xfer_t;

    // byte lanes are driven on writes, and on reads unless the window restricts them
    function automatic logic lanes_driven(input logic write, input logic wr_only);
        return write || !wr_only;
    endfunction

endpackage

// File: rtl/xbus_decode.sv
module xbus_decode
    import xbus_pkg::*;
#(
    parameter int NWIN = 6
) (
    input  logic [AW-1:0]            addr,
    input  logic [NWIN-1:0]          en,
    input  logic [NWIN-1:0][AW-1:0]  base,
    input  logic [NWIN-1:0][AW-1:0]  mask,
    output logic                     hit,
    output logic [WIN_IDX_W-1:0]     idx
);

    logic [NWIN-1:0] match;

    for (genvar i = 0; i < NWIN; i++) begin : g_cmp
        assign match[i] = en[i] && (((addr ^ base[i]) & ~mask[i]) == '0);
    end

    // lowest index wins: scan downward so the last assignment is the smallest
    always_comb begin
        idx = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (match[i]) idx = WIN_IDX_W'(i);
        end
    end

    assign hit = |match;

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int NWIN = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [AW-1:0]              req_addr,
    input  logic [DW-1:0]              req_wdata,
    input  logic [BW-1:0]              req_lanes,
    input  logic                       req_write,
    input  logic                       hit,
    input  logic [WIN_IDX_W-1:0]       hit_idx,
    input  logic [NWIN-1:0][WS_W-1:0]  win_ws,
    input  logic [NWIN-1:0]            win_exts,
    input  logic [NWIN-1:0]            win_wr_only,
    input  logic [DW-1:0]              bus_ad_in,
    output logic                       req_ready,
    output phase_t                     phase,
    output xfer_t                      xfer,
    output logic                       first_access,
    output logic                       rsp_done,
    output logic                       rsp_err,
    output logic [DW-1:0]              rsp_rdata
);

    logic [WS_W-1:0] wait_left;

    assign req_ready = (phase == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_IDLE;
            xfer         <= '0;
            wait_left    <= '0;
            first_access <= 1'b0;
            rsp_done     <= 1'b0;
            rsp_err      <= 1'b0;
            rsp_rdata    <= '0;
        end else begin
            rsp_done <= 1'b0;
            rsp_err  <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        if (hit) begin
                            xfer.addr    <= req_addr;
                            xfer.wdata   <= req_wdata;
                            xfer.lanes   <= req_lanes;
                            xfer.write   <= req_write;
                            xfer.win     <= hit_idx;
                            xfer.ws      <= win_ws[hit_idx];
                            xfer.exts    <= win_exts[hit_idx];
                            xfer.wr_only <= win_wr_only[hit_idx];
                            phase        <= PH_START;
                        end else begin
                            rsp_done <= 1'b1;
                            rsp_err  <= 1'b1;
                        end
                    end
                end
                PH_START: begin
                    phase        <= PH_ACCESS;
                    wait_left    <= xfer.ws;
                    first_access <= 1'b1;
                end
                PH_ACCESS: begin
                    first_access <= 1'b0;
                    if (wait_left == '0) begin
                        phase    <= PH_IDLE;
                        rsp_done <= 1'b1;
                        if (!xfer.write) rsp_rdata <= bus_ad_in;
                    end else begin
                        wait_left <= wait_left - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
    import xbus_pkg::*;
#(
    parameter int NWIN = 6
) (
    input  phase_t           phase,
    input  xfer_t            xfer,
    input  logic             first_access,
    input  logic             muxed,
    output logic [NWIN-1:0]  cs_n,
    output logic [BW-1:0]    be_n,
    output logic             oe_n,
    output logic             rw,
    output logic             ts_n,
    output logic             ale,
    output logic [AW-1:0]    addr,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe
);

    logic in_start;
    logic in_access;
    logic start_strobe;

    assign in_start     = (phase == PH_START);
    assign in_access    = (phase == PH_ACCESS);
    assign start_strobe = in_start || (in_access && first_access && xfer.exts);

    for (genvar i = 0; i < NWIN; i++) begin : g_cs
        assign cs_n[i] = !(in_access && (xfer.win == WIN_IDX_W'(i)));
    end

    always_comb begin
        be_n   = '1;
        if (in_access && lanes_driven(xfer.write, xfer.wr_only)) be_n = ~xfer.lanes;
        oe_n   = !(in_access && !xfer.write);
        rw     = !((in_start || in_access) && xfer.write);
        ts_n   = !start_strobe;
        ale    = muxed && start_strobe;
        addr   = (in_start || in_access) ? xfer.addr : '0;
        ad_oe  = (in_start && muxed) || (in_access && xfer.write);
        ad_out = '0;
        if (in_start && muxed)             ad_out = xfer.addr;
        else if (in_access && xfer.write)  ad_out = xfer.wdata;
    end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int NWIN = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_muxed,
    input  logic [NWIN-1:0]            win_en,
    input  logic [NWIN-1:0][AW-1:0]    win_base,
    input  logic [NWIN-1:0][AW-1:0]    win_mask,
    input  logic [NWIN-1:0][WS_W-1:0]  win_ws,
    input  logic [NWIN-1:0]            win_exts,
    input  logic [NWIN-1:0]            win_wr_only,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [AW-1:0]              req_addr,
    input  logic [DW-1:0]              req_wdata,
    input  logic [BW-1:0]              req_lanes,
    input  logic                       req_write,
    output logic                       rsp_done,
    output logic                       rsp_err,
    output logic [DW-1:0]              rsp_rdata,
    output logic [NWIN-1:0]            bus_cs_n,
    output logic [BW-1:0]              bus_be_n,
    output logic                       bus_oe_n,
    output logic                       bus_rw,
    output logic                       bus_ts_n,
    output logic                       bus_ale,
    output logic [AW-1:0]              bus_addr,
    output logic [DW-1:0]              bus_ad_out,
    output logic                       bus_ad_oe,
    input  logic [DW-1:0]              bus_ad_in
);

    logic                 hit;
    logic [WIN_IDX_W-1:0] hit_idx;
    phase_t               phase;
    xfer_t                xfer;
    logic                 first_access;

    xbus_decode #(.NWIN(NWIN)) u_decode (
        .addr (req_addr),
        .en   (win_en),
        .base (win_base),
        .mask (win_mask),
        .hit  (hit),
        .idx  (hit_idx)
    );

    xbus_seq #(.NWIN(NWIN)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_lanes    (req_lanes),
        .req_write    (req_write),
        .hit          (hit),
        .hit_idx      (hit_idx),
        .win_ws       (win_ws),
        .win_exts     (win_exts),
        .win_wr_only  (win_wr_only),
        .bus_ad_in    (bus_ad_in),
        .req_ready    (req_ready),
        .phase        (phase),
        .xfer         (xfer),
        .first_access (first_access),
        .rsp_done     (rsp_done),
        .rsp_err      (rsp_err),
        .rsp_rdata    (rsp_rdata)
    );

    xbus_pins #(.NWIN(NWIN)) u_pins (
        .phase        (phase),
        .xfer         (xfer),
        .first_access (first_access),
        .muxed        (cfg_muxed),
        .cs_n         (bus_cs_n),
        .be_n         (bus_be_n),
        .oe_n         (bus_oe_n),
        .rw           (bus_rw),
        .ts_n         (bus_ts_n),
        .ale          (bus_ale),
        .addr         (bus_addr),
        .ad_out       (bus_ad_out),
        .ad_oe        (bus_ad_oe)
    );

endmodule

// File: rtl/xbus_chk.sv
module xbus_chk #(
    parameter int NWIN = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            cfg_muxed,
    input logic            req_ready,
    input logic            rsp_done,
    input logic [NWIN-1:0] bus_cs_n,
    input logic [3:0]      bus_be_n,
    input logic            bus_oe_n,
    input logic            bus_rw,
    input logic            bus_ts_n,
    input logic            bus_ale
);

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~bus_cs_n)); // R2

    AST_OE_READ_SELECTED: assert property (@(posedge clk) disable iff (rst)
        !bus_oe_n |-> (bus_rw && (bus_cs_n != '1))); // R5

    AST_BE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        (bus_be_n != 4'hF) |-> (bus_cs_n != '1)); // R3

    AST_TS_STRETCH_WITH_CS: assert property (@(posedge clk) disable iff (rst)
        (!bus_ts_n && $past(!bus_ts_n)) |-> (bus_cs_n != '1)); // R8

    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (bus_cs_n == '1 && bus_ts_n && bus_oe_n)); // R11

    AST_ALE_SEPARATE_LOW: assert property (@(posedge clk) disable iff (rst)
        !cfg_muxed |-> !bus_ale); // R9

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (!bus_ts_n || bus_cs_n != '1) |-> !req_ready); // R13

endmodule

bind xbus_ctrl xbus_chk #(.NWIN(NWIN)) u_xbus_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_muxed (cfg_muxed),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .bus_cs_n  (bus_cs_n),
    .bus_be_n  (bus_be_n),
    .bus_oe_n  (bus_oe_n),
    .bus_rw    (bus_rw),
    .bus_ts_n  (bus_ts_n),
    .bus_ale   (bus_ale)
);

// File: tb/xbus_ctrl_bench.sv
`timescale 1ns/1ps
module xbus_ctrl_bench;

    localparam int NWIN = 6;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  cfg_muxed = 1'b0;
    logic [NWIN-1:0]       win_en;
    logic [NWIN-1:0][31:0] win_base;
    logic [NWIN-1:0][31:0] win_mask;
    logic [NWIN-1:0][3:0]  win_ws;
    logic [NWIN-1:0]       win_exts;
    logic [NWIN-1:0]       win_wr_only;
    logic                  req_valid = 1'b0;
    logic                  req_ready;
    logic [31:0]           req_addr = '0;
    logic [31:0]           req_wdata = '0;
    logic [3:0]            req_lanes = '0;
    logic                  req_write = 1'b0;
    logic                  rsp_done, rsp_err;
    logic [31:0]           rsp_rdata;
    logic [NWIN-1:0]       bus_cs_n;
    logic [3:0]            bus_be_n;
    logic                  bus_oe_n, bus_rw, bus_ts_n, bus_ale, bus_ad_oe;
    logic [31:0]           bus_addr, bus_ad_out;
    logic [31:0]           bus_ad_in = '0;

    always #2 clk = ~clk;

    xbus_ctrl #(.NWIN(NWIN)) u_xbus_ctrl (
        .clk(clk), .rst(rst), .cfg_muxed(cfg_muxed),
        .win_en(win_en), .win_base(win_base), .win_mask(win_mask),
        .win_ws(win_ws), .win_exts(win_exts), .win_wr_only(win_wr_only),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_lanes(req_lanes), .req_write(req_write),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_cs_n(bus_cs_n), .bus_be_n(bus_be_n), .bus_oe_n(bus_oe_n),
        .bus_rw(bus_rw), .bus_ts_n(bus_ts_n), .bus_ale(bus_ale),
        .bus_addr(bus_addr), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_ad_in(bus_ad_in)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          cyc = 0;
    bit          have = 0;
    int          acc = 0;
    int          m_win = -1;
    bit          m_write, m_mux, m_exts, m_wronly;
    int          m_ws;
    logic [31:0] m_addr, m_wdata;
    logic [3:0]  m_lanes;

    function automatic logic [31:0] pattern(input int k);
        return (32'(k) * 32'h0103_0507) ^ 32'hA5A5_0000;
    endfunction

    function automatic int lookup(input logic [31:0] a);
        int w = -1;
        for (int i = NWIN - 1; i >= 0; i--)
            if (win_en[i] && (((a ^ win_base[i]) & ~win_mask[i]) == 32'h0)) w = i;
        return w;
    endfunction

    function automatic bit model_ready();
        int off = cyc - acc - 1;
        if (!have || m_win < 0) return 1;
        return off > m_ws + 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            cyc  = 0;
            have = 0;
        end else begin
            if (req_valid && model_ready()) begin   // R13 handshake rule
                have     = 1;
                acc      = cyc;
                m_win    = lookup(req_addr);
                m_write  = req_write;
                m_addr   = req_addr;
                m_wdata  = req_wdata;
                m_lanes  = req_lanes;
                m_mux    = cfg_muxed;
                if (m_win >= 0) begin
                    m_ws     = int'(win_ws[m_win]);
                    m_exts   = win_exts[m_win];
                    m_wronly = win_wr_only[m_win];
                end
            end
            cyc = cyc + 1;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            int off;
            bit st, ac, dn, er;
            logic [NWIN-1:0] e_cs;
            logic [3:0] e_be;
            bit e_ts, e_ale, e_oe, e_rw, e_oe_ad, e_rdy;
            logic [31:0] e_addr, e_ad;
            off = cyc - acc - 1;
            st = have && m_win >= 0 && off == 0;
            ac = have && m_win >= 0 && off >= 1 && off <= m_ws + 1;
            dn = have && ((m_win >= 0 && off == m_ws + 2) || (m_win < 0 && off == 0));
            er = have && m_win < 0 && off == 0;
            e_cs = '1;
            if (ac) e_cs[m_win] = 1'b0;
            e_be = 4'hF;
            if (ac && (m_write || !m_wronly)) e_be = ~m_lanes;
            e_ts    = !(st || (ac && off == 1 && m_exts));
            e_ale   = m_mux && !e_ts && (st || ac);
            e_oe    = !(ac && !m_write);
            e_rw    = !((st || ac) && m_write);
            e_addr  = (st || ac) ? m_addr : 32'h0;
            e_oe_ad = (st && m_mux) || (ac && m_write);
            e_ad    = (st && m_mux) ? m_addr : ((ac && m_write) ? m_wdata : 32'h0);
            e_rdy   = !(st || ac);

            chk(bus_cs_n == e_cs, "R1 chip select", 64'(bus_cs_n), 64'(e_cs));
            chk(bus_be_n == e_be, (have && m_wronly && !m_write) ? "R4 byte enables" : "R3 byte enables",
                64'(bus_be_n), 64'(e_be));
            chk(bus_oe_n == e_oe, "R5 output enable", 64'(bus_oe_n), 64'(e_oe));
            chk(bus_rw == e_rw, "R6 read/write", 64'(bus_rw), 64'(e_rw));
            chk(bus_ts_n == e_ts, (have && m_exts) ? "R8 stretched strobe" : "R7 start strobe",
                64'(bus_ts_n), 64'(e_ts));
            chk(bus_ale == e_ale, "R9 latch enable", 64'(bus_ale), 64'(e_ale));
            chk(bus_addr == e_addr, "R7 address", 64'(bus_addr), 64'(e_addr));
            chk(bus_ad_oe == e_oe_ad, "R9 shared bus drive", 64'(bus_ad_oe), 64'(e_oe_ad));
            if (e_oe_ad) chk(bus_ad_out == e_ad, "R10 shared bus value", 64'(bus_ad_out), 64'(e_ad));
            chk(req_ready == e_rdy, "R13 ready", 64'(req_ready), 64'(e_rdy));
            chk(rsp_done == dn, er ? "R12 done" : "R11 done", 64'(rsp_done), 64'(dn));
            if (dn) chk(rsp_err == er, "R12 error flag", 64'(rsp_err), 64'(er));
            if (dn && !er && !m_write)
                chk(rsp_rdata == pattern(acc + m_ws + 2), "R10 read data capture",
                    64'(rsp_rdata), 64'(pattern(acc + m_ws + 2)));
        end
        bus_ad_in = pattern(cyc);
    end

    // ---------------- stimulus ----------------
    task automatic issue(input logic [31:0] a, input bit w, input logic [31:0] d, input logic [3:0] ln);
        @(negedge clk);
        req_addr  = a;
        req_write = w;
        req_wdata = d;
        req_lanes = ln;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (20) @(negedge clk);
    endtask

    task automatic run_set();
        issue(32'h1000_1234, 0, 32'h0, 4'hF);          // R2: windows 0 and 1 overlap, 0 wins, 0 waits
        wait_idle();
        issue(32'h1001_0010, 1, 32'hDEAD_BEEF, 4'h3);  // R8, R10: window 1, stretched, 3 waits
        wait_idle();
        issue(32'h10A0_0000, 0, 32'h0, 4'hC);          // R4: read in write-only window
        wait_idle();
        issue(32'h2001_2340, 1, 32'h1234_5678, 4'h8);  // R10: 15 waits
        wait_idle();
        issue(32'h3000_0ABC, 0, 32'h0, 4'h6);          // R3, R8: read drives lanes, stretched, 1 wait
        wait_idle();
        issue(32'h4000_0000, 0, 32'h0, 4'hF);          // R12: only a disabled window covers this
        issue(32'h5000_0000, 1, 32'h5555_AAAA, 4'h1);  // R12: outside all windows
        wait_idle();
        issue(32'h9234_5678, 1, 32'hCAFE_F00D, 4'hF);  // R1: high window, 2 waits
        issue(32'h8000_0004, 0, 32'h0, 4'h5);          // R13: queued behind the previous transfer
        wait_idle();
    endtask

    initial begin
        win_en      = 6'b101111;
        win_base[0] = 32'h1000_0000; win_mask[0] = 32'h0000_FFFF;
        win_base[1] = 32'h1000_0000; win_mask[1] = 32'h00FF_FFFF;
        win_base[2] = 32'h2000_0000; win_mask[2] = 32'h000F_FFFF;
        win_base[3] = 32'h3000_0000; win_mask[3] = 32'h0000_0FFF;
        win_base[4] = 32'h4000_0000; win_mask[4] = 32'h00FF_FFFF;
        win_base[5] = 32'h8000_0000; win_mask[5] = 32'h7FFF_FFFF;
        win_ws      = {4'd2, 4'd0, 4'd1, 4'd15, 4'd3, 4'd0};
        win_exts    = 6'b001010;
        win_wr_only = 6'b000110;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);                      // reset state checked by the model
        run_set();
        cfg_muxed = 1'b1;                               // R9: multiplexed layout
        run_set();
        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule